// File: doc/BRIEF.md
# External Timebase Window Supervisor

This block maintains a free-running count driven by an external timebase tick. When that tick stops arriving, the count falls back to an internal timebase. The internal timebase is a prescale counter. It runs on the local clock from zero up to a programmable wrap value and then returns to zero.

A detection window surrounds the prescaler's wrap point:
- The window opens when the prescaler count reaches a low compare value.
- It stays open through the rollover.
- It closes once the count passes a high compare value.

A rising tick edge that lands inside the window realigns the prescaler to zero. A rising tick edge outside the window has no effect.

If a window closes with no accepted edge, the block takes three actions:
- It switches its source to the internal prescaler.
- It can emit a one-cycle interrupt.
- It can add one extra count to the free-running counter, to make up for the lost tick.

Control returns to the external source only through an explicit re-arm strobe. The configuration must satisfy 0 < `win_hi_i` < `win_lo_i` <= `wrap_val_i`. The tick must stay high and stay low for at least two clock cycles each.

Top module: `ext_timebase_supervisor`

## Requirements
- R1: While rst_ni is low, presc_o reads 0, frc_o reads 0, ext_sel_o reads 1 (external source) and irq_o reads 0.
- R2: The prescaler adds one each clock. In a cycle where it reads wrap_val_i or more, it returns to 0 on the next clock.
- R3: ext_tick_i passes through a two-flop synchroniser, followed by a history flop. A rise of ext_tick_i driven between clock edges takes effect on the third rising clock edge after the rise.
- R4: The window is open when presc_o >= win_lo_i or presc_o <= win_hi_i. A tick edge that is evaluated while the window is shut changes neither presc_o nor frc_o.
- R5: An accepted tick edge (one inside the window) sets presc_o to 0 on that clock, whatever the current count.
- R6: With ext_sel_o = 1, frc_o adds one per accepted tick edge. With ext_sel_o = 0, frc_o adds one per clock on which presc_o equals or exceeds wrap_val_i.
- R7: A window close is the cycle in which presc_o equals win_hi_i + 1. A close is missed when ext_sel_o = 1 and no edge has been accepted since the previous close, the reset or the last re-arm. The close right after reset or re-arm is never missed. After a missed close, ext_sel_o becomes 0 on the next clock.
- R8: On a missed close with irq_en_i = 1, irq_o is 1 for exactly the next cycle. With irq_en_i = 0, irq_o stays 0.
- R9: On a missed close with comp_en_i = 1, frc_o gains one extra count on that clock. With comp_en_i = 0, it does not.
- R10: A cycle with rearm_i = 1 makes ext_sel_o 1 on the next clock. This holds even if a miss happens in that same cycle. The interrupt and the compensation count of that miss still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | External timebase tick, asynchronous |
| wrap_val_i | input | PRESC_W | Prescaler wrap value |
| win_lo_i | input | PRESC_W | Window low compare (opening point) |
| win_hi_i | input | PRESC_W | Window high compare (closing point) |
| irq_en_i | input | 1 | Interrupt enable for a missed tick |
| comp_en_i | input | 1 | One-count compensation enable for a missed tick |
| rearm_i | input | 1 | Strobe that returns the source to external |
| ext_sel_o | output | 1 | 1 = external tick drives the counter, 0 = internal prescaler |
| presc_o | output | PRESC_W | Prescaler count |
| frc_o | output | FRC_W | Free-running counter |
| irq_o | output | 1 | One-cycle missed-tick interrupt |

## Verification
A re-arm strobe and a missed window close can fall in the same cycle. This collision is provoked deliberately. After a re-arm, the bench lets one grace window pass and sends no ticks. It then holds rearm_i high in exactly the cycle where presc_o equals win_hi_i + 1. The cycle that follows must show all three of these together:
- ext_sel_o still 1;
- the interrupt pulse;
- the compensation count.

A behavioural reference model is compared against every output on every clock. The bench also checks this collision explicitly, and it separately checks the tick edge that lands on the wrap count.

// File: rtl/etb_pkg.sv
package etb_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/etb_edge_sync.sv
module etb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchroniser flops followed by one history flop
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/etb_prescaler.sv
module etb_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         resync_i,
  input  logic [W-1:0] wrap_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q >= wrap_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (resync_i || wrap_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/etb_window.sv
module etb_window #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         open_o,
  output logic         close_o
);
  // window straddles rollover: open above lo or below hi
  assign open_o  = (cnt_i >= lo_i) || (cnt_i <= hi_i);
  assign close_o = (cnt_i == hi_i + W'(1));
endmodule

// File: rtl/etb_src_ctrl.sv
module etb_src_ctrl
  import etb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic close_i,
  input  logic rearm_i,
  input  logic irq_en_i,
  output logic ext_sel_o,
  output logic miss_o,
  output logic irq_o
);
  src_e src_q;
  logic seen_q;
  logic irq_q;

  // seen_q starts set so the first close after reset or rearm is a grace window
  assign miss_o = (src_q == SRC_EXT) && close_i && !(seen_q || accept_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_EXT;
      seen_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= miss_o && irq_en_i;
      if (rearm_i)      seen_q <= 1'b1;
      else if (close_i) seen_q <= 1'b0;
      else if (accept_i) seen_q <= 1'b1;
      if (rearm_i)     src_q <= SRC_EXT;
      else if (miss_o) src_q <= SRC_INT;
    end
  end

  assign ext_sel_o = (src_q == SRC_EXT);
  assign irq_o     = irq_q;
endmodule

// File: rtl/etb_frc.sv
module etb_frc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         comp_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + W'(inc_i) + W'(comp_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ext_timebase_supervisor.sv
module ext_timebase_supervisor #(
  parameter int unsigned PRESC_W     = 16,
  parameter int unsigned FRC_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_tick_i,
  input  logic [PRESC_W-1:0] wrap_val_i,
  input  logic [PRESC_W-1:0] win_lo_i,
  input  logic [PRESC_W-1:0] win_hi_i,
  input  logic               irq_en_i,
  input  logic               comp_en_i,
  input  logic               rearm_i,
  output logic               ext_sel_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [FRC_W-1:0]   frc_o,
  output logic               irq_o
);
  logic tick_rise;
  logic win_open, win_close;
  logic accept, wrap, miss;
  logic frc_inc, frc_comp;

  etb_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_tick_i),
    .rise_o  (tick_rise)
  );

  etb_window #(.W(PRESC_W)) i_win (
    .cnt_i   (presc_o),
    .lo_i    (win_lo_i),
    .hi_i    (win_hi_i),
    .open_o  (win_open),
    .close_o (win_close)
  );

  assign accept = tick_rise && win_open;

  etb_prescaler #(.W(PRESC_W)) i_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .resync_i   (accept),
    .wrap_val_i (wrap_val_i),
    .cnt_o      (presc_o),
    .wrap_o     (wrap)
  );

  etb_src_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .close_i   (win_close),
    .rearm_i   (rearm_i),
    .irq_en_i  (irq_en_i),
    .ext_sel_o (ext_sel_o),
    .miss_o    (miss),
    .irq_o     (irq_o)
  );

  assign frc_inc  = ext_sel_o ? accept : wrap;
  assign frc_comp = miss && comp_en_i;

  etb_frc #(.W(FRC_W)) i_frc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (frc_inc),
    .comp_i (frc_comp),
    .cnt_o  (frc_o)
  );
endmodule

// File: rtl/etb_checker.sv
module etb_checker #(
  parameter int unsigned PRESC_W = 16,
  parameter int unsigned FRC_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PRESC_W-1:0] wrap_val_i,
  input logic [PRESC_W-1:0] win_hi_i,
  input logic               irq_en_i,
  input logic               rearm_i,
  input logic               ext_sel_o,
  input logic [PRESC_W-1:0] presc_o,
  input logic [FRC_W-1:0]   frc_o,
  input logic               irq_o
);
  // R2
  wrap_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_o >= wrap_val_i) |=> (presc_o == '0));

  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8
  irq_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i));

  // R7
  fall_at_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_sel_o) |-> ($past(presc_o) == $past(win_hi_i) + PRESC_W'(1)));

  // R10
  rearm_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> ext_sel_o);

  // R9
  frc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_o - $past(frc_o)) <= FRC_W'(2));
endmodule

bind ext_timebase_supervisor etb_checker #(.PRESC_W(PRESC_W), .FRC_W(FRC_W)) i_etb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wrap_val_i (wrap_val_i),
  .win_hi_i   (win_hi_i),
  .irq_en_i   (irq_en_i),
  .rearm_i    (rearm_i),
  .ext_sel_o  (ext_sel_o),
  .presc_o    (presc_o),
  .frc_o      (frc_o),
  .irq_o      (irq_o)
);

// File: tb/test_ext_timebase_supervisor.sv
module test_ext_timebase_supervisor;
  localparam int PW = 16;
  localparam int FW = 32;
  localparam int WRAP = 19;
  localparam int LO = 16;
  localparam int HI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic irq_en = 1'b1;
  logic comp_en = 1'b1;
  logic rearm = 1'b0;
  logic ext_sel, irq;
  logic [PW-1:0] presc;
  logic [FW-1:0] frc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_timebase_supervisor #(.PRESC_W(PW), .FRC_W(FW)) i_ext_timebase_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .ext_tick_i(tick),
    .wrap_val_i(PW'(WRAP)), .win_lo_i(PW'(LO)), .win_hi_i(PW'(HI)),
    .irq_en_i(irq_en), .comp_en_i(comp_en), .rearm_i(rearm),
    .ext_sel_o(ext_sel), .presc_o(presc), .frc_o(frc), .irq_o(irq)
  );

  // behavioural reference model
  bit hist[$];
  int m_cnt, m_frc;
  bit m_ext, m_seen, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_frc = 0; m_ext = 1; m_seen = 1; m_irq = 0;
    end else begin
      bit rise, acc, cls, miss, inc;
      rise = hist[1] && !hist[2];
      acc  = rise && (m_cnt >= LO || m_cnt <= HI);
      cls  = (m_cnt == HI + 1);
      miss = m_ext && cls && !(m_seen || acc);
      inc  = m_ext ? acc : (m_cnt >= WRAP);
      m_frc = m_frc + int'(inc) + int'(miss && comp_en);
      m_irq = miss && irq_en;
      if (rearm) m_seen = 1;
      else if (cls) m_seen = 0;
      else if (acc) m_seen = 1;
      if (rearm) m_ext = 1;
      else if (miss) m_ext = 0;
      m_cnt = (acc || m_cnt >= WRAP) ? 0 : m_cnt + 1;
      hist.push_front(tick);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R5 presc", presc, m_cnt);
      check("R6/R9 frc", frc, m_frc);
      check("R7/R10 ext_sel", ext_sel, m_ext);
      check("R8 irq", irq, m_irq);
    end
  end

  task automatic wait_presc(input int v);
    do @(negedge clk); while (presc != PW'(v));
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    repeat (8) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    longint f0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 presc", presc, 0);
    check("R1 frc", frc, 0);
    check("R1 ext_sel", ext_sel, 1);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;

    // R3 R5 R6: in-window edges, acted on the third edge
    for (int i = 0; i < 3; i++) begin
      wait_presc(LO);
      f0 = frc;
      tick = 1'b1;
      repeat (3) @(negedge clk);
      check("R3 presc zero after sync", presc, 0);
      check("R6 ext count", frc, f0 + 1);
      repeat (5) @(negedge clk);
      tick = 1'b0;
    end

    // edge at the wrap count: one count only
    wait_presc(WRAP - 2);
    f0 = frc;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 edge at wrap", presc, 0);
    check("R6 edge at wrap single count", frc, f0 + 1);
    repeat (5) @(negedge clk);
    tick = 1'b0;

    // R4: outside-window edge ignored
    wait_presc(8);
    f0 = frc;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 presc unaffected", presc, 11);
    check("R4 frc unaffected", frc, f0);
    repeat (5) @(negedge clk);
    tick = 1'b0;

    // R7 R8 R9: missed close
    wait_presc(HI + 1);
    f0 = frc;
    @(negedge clk);
    check("R7 fallback", ext_sel, 0);
    check("R8 irq pulse", irq, 1);
    check("R9 compensation", frc, f0 + 1);
    @(negedge clk);
    check("R8 irq one cycle", irq, 0);

    // R6 internal counting
    wait_presc(WRAP);
    f0 = frc;
    @(negedge clk);
    check("R6 internal wrap count", frc, f0 + 1);

    // R10: plain rearm
    wait_presc(10);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    check("R10 rearm", ext_sel, 1);

    // R10: rearm colliding with a missed close (grace close first)
    wait_presc(HI + 1);
    wait_presc(HI);
    @(negedge clk);
    check("R7 close reached", presc, HI + 1);
    f0 = frc;
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    check("R10 collision ext kept", ext_sel, 1);
    check("R10 collision irq", irq, 1);
    check("R10 collision comp", frc, f0 + 1);

    // R8 R9 disabled
    irq_en = 1'b0;
    comp_en = 1'b0;
    wait_presc(HI + 1);
    wait_presc(HI + 1);
    f0 = frc;
    @(negedge clk);
    check("R7 fallback again", ext_sel, 0);
    check("R8 irq disabled", irq, 0);
    check("R9 comp disabled", frc, f0);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule